// File: doc/BRIEF.md
# Multiframe-Aligned Circular Transmit Buffer

This block feeds a framer's data link transmitter one bit at a time. It has two operating modes chosen by a mode input. In queue mode it is a plain first-in, first-out store: each processor write appends one byte, and the serial side drains bytes in arrival order, least significant bit first.

In loop mode the processor loads a message of up to 64 bytes and then commits it with an end-of-message strobe. Nothing is sent on commit. The message starts, from its first byte and first bit, at the next multiframe-start pulse. From then on it repeats without end, wrapping back to its first byte after its last committed byte. A second message can be loaded while the first is still repeating. The new message replaces the old one only at the first multiframe start that follows its own commit. A packing input picks whether 8 or only the low 6 bits of each byte go out on the line.

The downstream side shows the current line bit on `tx_bit` at all times. It moves on to the next bit on each clock cycle in which `bit_req` is high. Framing itself is generated elsewhere.

Top module: `dl_loop_tx_buffer`

## Requirements
- R1: After reset `tx_bit` is 1 and `ovf_flag` is 0 in both modes.
- R2: In queue mode (`loop_mode`=0, `pack6`=0) bytes leave in write order. Each byte leaves as bits 0 through 7, bit 0 first, and one bit is consumed per cycle with `bit_req` high.
- R3: With `pack6`=1, only bits 0 through 5 of each byte are sent, bit 0 first. Bits 6 and 7 are skipped. This holds in both modes.
- R4: In queue mode with an empty store, `tx_bit` is 1 and `bit_req` has no effect: the next byte written still starts from its bit 0.
- R5: The queue holds 64 bytes. A write while it is full is dropped and sets `ovf_flag`. The 64 stored bytes still leave intact and in order.
- R6: In loop mode, `tx_bit` is 1 until a message has started. Loaded bytes are not sent before a commit and a following multiframe start.
- R7: A committed message starts at byte 0, bit 0, in the cycle after the first `mf_start` that follows its commit cycle. An `mf_start` in the same cycle as `msg_end` does not start it. A write in the commit cycle is part of the message.
- R8: A running message repeats endlessly. After its last committed byte it continues with byte 0.
- R9: While a new message is being loaded and while its commit is waiting, the old message keeps repeating unchanged. At the next `mf_start` the new message takes over from byte 0, bit 0, even if the old one was in the middle of a byte.
- R10: In loop mode, writes past 64 bytes before `msg_end` are dropped and set `ovf_flag`. The message then consists of the first 64 bytes.
- R11: In loop mode, writes and `msg_end` while a commit is waiting are ignored. `msg_end` with no bytes loaded is ignored.
- R12: `ovf_flag` stays 1 once set, until reset.
- R13: Changing `loop_mode` clears the mode being left. After a switch into queue mode the queue is empty. After a switch into loop mode nothing is loaded, committed or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_mode | input | 1 | 1 selects loop mode, 0 selects queue mode |
| pack6 | input | 1 | 1 sends 6 bits per byte, 0 sends 8 |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Processor write byte |
| msg_end | input | 1 | End-of-message commit strobe (loop mode) |
| mf_start | input | 1 | Pulse marking the start of a transmit multiframe |
| bit_req | input | 1 | Downstream consumes the current bit this cycle |
| tx_bit | output | 1 | Current line bit (1 when idle) |
| ovf_flag | output | 1 | Sticky flag for a dropped write |

## Verification
The bench targets several corner cases, each tied to a specific failure:
- Commit and multiframe start in the same cycle: a design that starts there would shift the whole pattern by one multiframe.
- Takeover in the middle of a byte: a design that keeps the old bit index would start the new message misaligned.
- A message grown past 64 bytes: a design that does not stop at 64 would wrap the write index and overwrite byte 0.
- Writes and a second commit while a commit is waiting: a design that accepts these would corrupt the message about to start.
- Requests against an empty queue: a design that advances the bit index there would start the next byte part-way through.

Randomised runs in both modes and both packings compare every line bit against a model built in the bench.

// File: rtl/dl_loop_pkg.sv
package dl_loop_pkg;

    localparam int DL_BYTE_W = 8;
    localparam int DL_BIT_W  = $clog2(DL_BYTE_W);

    typedef logic [DL_BYTE_W-1:0] dl_byte_t;
    typedef logic [DL_BIT_W-1:0]  dl_bit_idx_t;

    typedef enum logic {
        LP_IDLE = 1'b0,
        LP_RUN  = 1'b1
    } dl_loop_state_e;

    // index of the last bit sent from a byte for the chosen packing
    function automatic dl_bit_idx_t dl_last_bit(input logic pack6);
        return pack6 ? dl_bit_idx_t'(5) : dl_bit_idx_t'(DL_BYTE_W - 1);
    endfunction

    // pick one bit of a byte
    function automatic logic dl_pick(input dl_byte_t b, input dl_bit_idx_t i);
        return b[i];
    endfunction

endpackage

// File: rtl/dl_bank_store.sv
module dl_bank_store
    import dl_loop_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  dl_byte_t                 wr_data,
    input  logic                     rd_bank,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output dl_byte_t                 rd_data
);
    localparam int AW = $clog2(DEPTH);

    dl_byte_t mem [2*DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_idx}] <= wr_data;
        end
    end

    assign rd_data = mem[{rd_bank, rd_idx}];

    initial begin
        assert (AW >= 1) else $error("dl_bank_store depth too small");
    end

endmodule

// File: rtl/dl_fifo_path.sv
module dl_fifo_path
    import dl_loop_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     wr_en,
    input  dl_byte_t wr_data,
    input  logic     pack6,
    input  logic     bit_req,
    output logic     tx_bit,
    output logic     drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    dl_byte_t           mem [DEPTH];
    logic [AW-1:0]      wp, rp;
    logic [CW-1:0]      cnt;
    dl_bit_idx_t        bit_idx;

    logic full, empty, push, pop, adv, at_last;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push    = wr_en && !full;
    assign drop    = wr_en && full;
    assign adv     = bit_req && !empty;
    assign at_last = (bit_idx >= dl_last_bit(pack6));
    assign pop     = adv && at_last;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            if (push) wp <= ptr_next(wp);
            if (pop)  rp <= ptr_next(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
            if (adv) begin
                bit_idx <= at_last ? '0 : bit_idx + 1'b1;
            end
        end
    end

    assign tx_bit = empty ? 1'b1 : dl_pick(mem[rp], bit_idx);

    // R5: occupancy never exceeds the depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R5: a dropped write without a pop leaves the queue full
    a_r5_drop_full: assert property (@(posedge clk) disable iff (rst || flush)
        (drop && !bit_req) |=> (cnt == CW'(DEPTH)));

    // R4: an empty queue with no write stays at bit 0
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (rst || flush)
        (empty && !wr_en) |=> (bit_idx == '0 && tx_bit));

endmodule

// File: rtl/dl_loop_path.sv
module dl_loop_path
    import dl_loop_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     wr_en,
    input  dl_byte_t wr_data,
    input  logic     msg_end,
    input  logic     mf_start,
    input  logic     pack6,
    input  logic     bit_req,
    output logic     tx_bit,
    output logic     drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          bank;
        logic [CW-1:0] len;
        logic [AW-1:0] byte_idx;
        dl_bit_idx_t   bit_idx;
    } play_pos_t;

    dl_loop_state_e st;
    play_pos_t      play;
    logic           pend;
    logic [CW-1:0]  pend_len;
    logic [CW-1:0]  ld_cnt;

    logic     ld_full, acc_wr, commit, swap, advance, at_last, at_end, running;
    dl_byte_t rd_data;

    assign running = (st == LP_RUN);
    assign ld_full = (ld_cnt == CW'(DEPTH));
    assign acc_wr  = enable && wr_en && !pend && !ld_full;
    assign drop    = enable && wr_en && !pend && ld_full;
    assign commit  = enable && msg_end && !pend && (acc_wr || ld_cnt != '0);
    assign swap    = enable && mf_start && pend;
    assign advance = running && bit_req && !swap;
    assign at_last = (play.bit_idx >= dl_last_bit(pack6));
    assign at_end  = ((CW'(play.byte_idx) + 1'b1) == play.len);

    dl_bank_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .wr_en   (acc_wr),
        .wr_bank (~play.bank),
        .wr_idx  (ld_cnt[AW-1:0]),
        .wr_data (wr_data),
        .rd_bank (play.bank),
        .rd_idx  (play.byte_idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st       <= LP_IDLE;
            play     <= '0;
            pend     <= 1'b0;
            pend_len <= '0;
            ld_cnt   <= '0;
        end else begin
            if (acc_wr) ld_cnt <= ld_cnt + 1'b1;
            if (commit) begin
                pend     <= 1'b1;
                pend_len <= ld_cnt + CW'(acc_wr);
                ld_cnt   <= '0;
            end
            if (swap) begin
                st            <= LP_RUN;
                play.bank     <= ~play.bank;
                play.len      <= pend_len;
                play.byte_idx <= '0;
                play.bit_idx  <= '0;
                pend          <= 1'b0;
            end else if (advance) begin
                if (at_last) begin
                    play.bit_idx  <= '0;
                    play.byte_idx <= at_end ? '0 : play.byte_idx + 1'b1;
                end else begin
                    play.bit_idx <= play.bit_idx + 1'b1;
                end
            end
        end
    end

    assign tx_bit = running ? dl_pick(rd_data, play.bit_idx) : 1'b1;

    // R6: nothing but ones before a message has started
    a_r6_idle_ones: assert property (@(posedge clk) disable iff (rst)
        !running |-> tx_bit);

    // R9: takeover restarts at byte 0, bit 0
    a_r9_swap_restart: assert property (@(posedge clk) disable iff (rst || !enable)
        swap |=> (running && play.byte_idx == '0 && play.bit_idx == '0 && !pend));

    // R8: the replay index stays inside the committed length
    a_r8_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        running |-> (CW'(play.byte_idx) < play.len));

    // R10: the load count never passes the depth
    a_r10_load_bound: assert property (@(posedge clk) disable iff (rst)
        ld_cnt <= CW'(DEPTH));

    // R11: a waiting commit is only retired by a multiframe start
    a_r11_pend_hold: assert property (@(posedge clk) disable iff (rst || !enable)
        (pend && !mf_start) |=> pend);

    // R11: nothing is loaded while a commit waits
    a_r11_no_load: assert property (@(posedge clk) disable iff (rst || !enable)
        (pend && !mf_start) |=> $stable(ld_cnt));

endmodule

// File: rtl/dl_loop_tx_buffer.sv
module dl_loop_tx_buffer
    import dl_loop_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       loop_mode,
    input  logic       pack6,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       msg_end,
    input  logic       mf_start,
    input  logic       bit_req,
    output logic       tx_bit,
    output logic       ovf_flag
);
    logic fifo_bit, fifo_drop, loop_bit, loop_drop;

    dl_fifo_path #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (loop_mode),
        .wr_en   (wr_en && !loop_mode),
        .wr_data (wr_data),
        .pack6   (pack6),
        .bit_req (bit_req && !loop_mode),
        .tx_bit  (fifo_bit),
        .drop    (fifo_drop)
    );

    dl_loop_path #(.DEPTH(DEPTH)) loop_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (loop_mode),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .msg_end  (msg_end),
        .mf_start (mf_start),
        .pack6    (pack6),
        .bit_req  (bit_req),
        .tx_bit   (loop_bit),
        .drop     (loop_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else if (fifo_drop || loop_drop) begin
            ovf_flag <= 1'b1;
        end
    end

    assign tx_bit = loop_mode ? loop_bit : fifo_bit;

    // R12: the overflow flag is sticky
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    // R1: reset leaves an idle line and a clear flag
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_bit && !ovf_flag));

endmodule

// File: tb/dl_loop_tx_buffer_tb.sv
module dl_loop_tx_buffer_tb_top;

    logic       clk = 1'b0;
    logic       rst, loop_mode, pack6, wr_en, msg_end, mf_start, bit_req;
    logic [7:0] wr_data;
    logic       tx_bit, ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dl_loop_tx_buffer #(.DEPTH(64)) dut_i (
        .clk(clk), .rst(rst), .loop_mode(loop_mode), .pack6(pack6),
        .wr_en(wr_en), .wr_data(wr_data), .msg_end(msg_end),
        .mf_start(mf_start), .bit_req(bit_req),
        .tx_bit(tx_bit), .ovf_flag(ovf_flag)
    );

    logic [7:0] q[$];
    logic [7:0] m_msg [64];
    int         m_len, m_byte, m_bit;

    function automatic int last_of(input logic p6);
        return p6 ? 5 : 7;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; msg_end = 0; mf_start = 0; bit_req = 0; wr_data = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        m_len = 0;
    endtask

    task automatic cpu_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_eom();
        msg_end = 1'b1;
        @(negedge clk);
        msg_end = 1'b0;
    endtask

    task automatic pulse_mf();
        mf_start = 1'b1;
        @(negedge clk);
        mf_start = 1'b0;
    endtask

    task automatic take_bit(output logic b);
        #1 b = tx_bit;
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
    endtask

    // drain the queue model and compare every bit
    task automatic drain_queue(input string tag);
        logic b;
        while (q.size() != 0) begin
            logic [7:0] v = q.pop_front();
            for (int i = 0; i <= last_of(pack6); i++) begin
                take_bit(b);
                chk(b == v[i], tag, int'(b), int'(v[i]));
            end
        end
    endtask

    // start a fresh replay model from a message
    task automatic model_start(input logic [7:0] src [64], input int len);
        for (int i = 0; i < 64; i++) m_msg[i] = src[i];
        m_len = len; m_byte = 0; m_bit = 0;
    endtask

    task automatic loop_expect(input int nbits, input string tag);
        logic b;
        for (int i = 0; i < nbits; i++) begin
            logic e = m_msg[m_byte][m_bit];
            take_bit(b);
            chk(b == e, tag, int'(b), int'(e));
            if (m_bit >= last_of(pack6)) begin
                m_bit = 0;
                m_byte = (m_byte + 1 == m_len) ? 0 : m_byte + 1;
            end else begin
                m_bit++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       b;
        logic [7:0] msg_a [64];
        logic [7:0] msg_b [64];
        int         n;
        void'($urandom(32'd2024));

        rst = 1; loop_mode = 0; pack6 = 0; wr_en = 0; wr_data = 0;
        msg_end = 0; mf_start = 0; bit_req = 0;
        do_reset();

        // R1: reset state
        #1;
        chk(tx_bit == 1'b1, "R1 tx idle", int'(tx_bit), 1);
        chk(ovf_flag == 1'b0, "R1 ovf clear", int'(ovf_flag), 0);

        // R2 / R3: random queue traffic in both packings
        for (int r = 0; r < 6; r++) begin
            pack6 = r[0];
            n = 1 + int'($urandom_range(0, 20));
            for (int i = 0; i < n; i++) begin
                logic [7:0] v = 8'($urandom);
                q.push_back(v);
                cpu_write(v);
            end
            drain_queue(pack6 ? "R3 queue pack6" : "R2 queue order");
        end
        pack6 = 0;

        // R4: empty queue ignores requests
        #1 chk(tx_bit == 1'b1, "R4 empty idle", int'(tx_bit), 1);
        for (int i = 0; i < 3; i++) take_bit(b);
        cpu_write(8'h5A);
        take_bit(b);
        chk(b == 1'b0, "R4 starts at bit0", int'(b), 0);
        take_bit(b);
        chk(b == 1'b1, "R4 then bit1", int'(b), 1);
        for (int i = 2; i < 8; i++) take_bit(b);

        // R5: 65 writes into a 64-byte queue
        #1 chk(ovf_flag == 1'b0, "R5 ovf before", int'(ovf_flag), 0);
        for (int i = 0; i < 65; i++) begin
            logic [7:0] v = 8'($urandom);
            if (i < 64) q.push_back(v);
            cpu_write(v);
        end
        #1 chk(ovf_flag == 1'b1, "R5 ovf set", int'(ovf_flag), 1);
        drain_queue("R5 stored bytes");
        // R12: flag still set after the queue has drained
        #1 chk(ovf_flag == 1'b1, "R12 ovf sticky", int'(ovf_flag), 1);

        // loop mode basic
        do_reset();
        loop_mode = 1; pack6 = 0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) msg_a[i] = 8'($urandom);
        cpu_write(msg_a[0]);
        cpu_write(msg_a[1]);
        for (int i = 0; i < 4; i++) take_bit(b);
        chk(b == 1'b1, "R6 held before commit", int'(b), 1);
        // third byte written in the commit cycle, mf_start in the same cycle
        wr_en = 1; wr_data = msg_a[2]; msg_end = 1; mf_start = 1;
        @(negedge clk);
        wr_en = 0; msg_end = 0; mf_start = 0;
        take_bit(b);
        chk(b == 1'b1, "R7 no start with commit", int'(b), 1);
        take_bit(b);
        chk(b == 1'b1, "R6 idle while waiting", int'(b), 1);
        pulse_mf();
        model_start(msg_a, 3);
        loop_expect(8, "R7 first byte");
        loop_expect(3 * 8 * 3, "R8 wraps");

        // R9: reload while running
        for (int i = 0; i < 64; i++) msg_b[i] = 8'($urandom);
        for (int i = 0; i < 5; i++) begin
            cpu_write(msg_b[i]);
            loop_expect(3, "R9 old runs while loading");
        end
        pulse_eom();
        loop_expect(11, "R9 old runs while waiting");
        cpu_write(8'hFF);
        pulse_eom();
        loop_expect(3, "R11 ignored while waiting");
        pulse_mf();
        model_start(msg_b, 5);
        loop_expect(5 * 8 * 2 + 4, "R9 new takes over");
        loop_expect(40, "R11 len unchanged");

        // R10: overflow in loop mode
        do_reset();
        loop_mode = 1; pack6 = 1;
        @(negedge clk);
        for (int i = 0; i < 70; i++) begin
            logic [7:0] v = 8'($urandom);
            if (i < 64) msg_a[i] = v;
            cpu_write(v);
        end
        #1 chk(ovf_flag == 1'b1, "R10 ovf set", int'(ovf_flag), 1);
        pulse_eom();
        pulse_mf();
        model_start(msg_a, 64);
        loop_expect(64 * 6 + 12, "R10 64 bytes and R3 pack6 loop");

        // random loop rounds
        for (int r = 0; r < 6; r++) begin
            pack6 = r[1];
            n = 1 + int'($urandom_range(0, 63));
            for (int i = 0; i < n; i++) begin
                msg_b[i] = 8'($urandom);
                cpu_write(msg_b[i]);
            end
            pulse_eom();
            loop_expect(int'($urandom_range(0, 9)), "R9 old before swap");
            pulse_mf();
            model_start(msg_b, n);
            loop_expect(n * (last_of(pack6) + 1) + 7, "R8 random replay");
        end

        // R13: mode switches clear the mode left behind
        loop_mode = 0;
        @(negedge clk);
        #1 chk(tx_bit == 1'b1, "R13 queue empty after switch", int'(tx_bit), 1);
        cpu_write(8'h0F);
        loop_mode = 1;
        @(negedge clk);
        take_bit(b);
        chk(b == 1'b1, "R13 loop idle after switch", int'(b), 1);
        pulse_mf();
        take_bit(b);
        chk(b == 1'b1, "R13 nothing committed", int'(b), 1);
        loop_mode = 0;
        @(negedge clk);
        #1 chk(tx_bit == 1'b1, "R13 queue flushed", int'(tx_bit), 1);

        // R11: empty commit ignored
        loop_mode = 1;
        @(negedge clk);
        pulse_eom();
        pulse_mf();
        take_bit(b);
        chk(b == 1'b1, "R11 empty commit", int'(b), 1);
        cpu_write(8'h00);
        pulse_eom();
        pulse_mf();
        take_bit(b);
        chk(b == 1'b0, "R11 later commit works", int'(b), 0);

        // R12 / R1: reset clears the flag
        #1 chk(ovf_flag == 1'b1, "R12 still set", int'(ovf_flag), 1);
        do_reset();
        #1 chk(ovf_flag == 1'b0, "R1 ovf cleared by reset", int'(ovf_flag), 0);
        chk(tx_bit == 1'b1, "R1 tx idle after reset", int'(tx_bit), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule